// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a 32.768 kHz time-base tick into a programmable periodic event. A four-bit rate code selects a power-of-two period in time-base ticks. The event drives two consumers. The periodic-interrupt consumer receives a status-flag set pulse. The square-wave consumer receives an output pulse.

A free-running tick counter sets the timing of each event, not a counter that reloads at every event. Every event therefore falls on a multiple of the selected period. A change of rate takes effect at the next tick. The first event after a change comes at the next multiple of the new period. The divider produces nothing unless the rate code is nonzero and at least one consumer is enabled.

Top module: `periodic_rate_divider`

## Requirements
- R1: A synchronous active-high `rst` clears the tick count and all outputs. After reset, the first event follows the tick that brings the count since reset to one full period.
- R2: Rate code 0 stops the divider. No output pulses while the code is 0, even if ticks arrive.
- R3: With both `pie_en` and `sqw_en` low, no output pulses, whatever the rate code.
- R4: For codes 3 to 15, the period is 2^(code-1) ticks. For example, code 6 gives 32 ticks and code 15 gives 16384.
- R5: Codes 1 and 2 act as codes 8 and 9, giving periods of 128 and 256 ticks.
- R6: An event occurs on the tick that brings the free-running tick count to a multiple of the period. `evt_o` is high in the clock cycle after that tick.
- R7: `flags_o` is a two-bit pulse. Bit 1 is the interrupt-request flag and bit 0 is the periodic flag. It is 2'b11 with each event while `pie_en` is set, and 2'b00 otherwise.
- R8: `sqw_o` pulses with each event while `sqw_en` is set, and stays low while `sqw_en` is clear.
- R9: After a rate change, the next event falls at the next multiple of the new period on the same free-running count. The count does not restart.
- R10: Each pulse lasts one clock cycle, even with ticks on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle time-base tick enable (32.768 kHz) |
| rate_sel | input | 4 | Rate code; 0 stops the divider |
| pie_en | input | 1 | Periodic-interrupt consumer enable |
| sqw_en | input | 1 | Square-wave consumer enable |
| evt_o | output | 1 | One-cycle periodic event |
| flags_o | output | 2 | Flag-set pulse: {interrupt request, periodic} |
| sqw_o | output | 1 | Square-wave pulse |

## Verification
The bench targets the following corner cases.
- Aliased codes 1 and 2: a design that decodes them literally would fire every 1 or 2 ticks instead of every 128 or 256.
- Code 15: a mask that drops the top bit would fire at 8192 ticks, or never.
- A rate change partway through a period: a design that reloads its divider would place the next event relative to the write, not on the shared tick count.
- Ticks on every cycle: these would expose stretched pulses.
- Idle phases, with code 0 or with no consumer enabled, that still carry ticks: a gated design that also froze the count would shift every later event.

// File: rtl/periodic_rate_divider.sv
module periodic_rate_divider #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pie_en,
  input  logic              sqw_en,
  output logic              evt_o,
  output logic [1:0]        flags_o,
  output logic              sqw_o
);
  localparam int CNT_W = (1 << RATE_W) - 2;

  logic [CNT_W-1:0]  tb_cnt, tb_nxt, mask;
  logic [CNT_W:0]    span;
  logic [RATE_W-1:0] code_eff;
  logic              running, boundary, fire;

  assign code_eff = (rate_sel == RATE_W'(1)) ? RATE_W'(8) :
                    (rate_sel == RATE_W'(2)) ? RATE_W'(9) : rate_sel;
  assign span     = (CNT_W+1)'(1) << (code_eff - RATE_W'(1));
  assign mask     = span[CNT_W-1:0] - CNT_W'(1);
  assign running  = (rate_sel != '0) && (pie_en || sqw_en);
  assign tb_nxt   = tb_cnt + CNT_W'(1);
  assign boundary = (tb_nxt & mask) == '0;
  assign fire     = tick_en && running && boundary;

  always_ff @(posedge clk) begin
    if (rst) begin
      tb_cnt  <= '0;
      evt_o   <= 1'b0;
      flags_o <= 2'b00;
      sqw_o   <= 1'b0;
    end else begin
      if (tick_en) tb_cnt <= tb_nxt;
      evt_o   <= fire;
      flags_o <= {2{fire && pie_en}};
      sqw_o   <= fire && sqw_en;
    end
  end

  assert_evt_needs_tick_R6: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> $past(tick_en));
  assert_zero_rate_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == '0) |=> !evt_o);
  assert_no_consumer_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!pie_en && !sqw_en) |=> !evt_o);
  assert_flags_with_evt_R7: assert property (@(posedge clk) disable iff (rst)
    (flags_o != 2'b00) |-> (evt_o && flags_o == 2'b11));
  assert_sqw_with_evt_R8: assert property (@(posedge clk) disable iff (rst)
    sqw_o |-> evt_o);
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> !evt_o);
endmodule

// File: tb/sim_periodic_rate_divider.sv
module sim_periodic_rate_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       pie_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic       evt_o, sqw_o;
  logic [1:0] flags_o;

  periodic_rate_divider u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rate_sel(rate_sel),
    .pie_en(pie_en), .sqw_en(sqw_en),
    .evt_o(evt_o), .flags_o(flags_o), .sqw_o(sqw_o)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int         stamp;
    logic [1:0] fl;
    logic       sq;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   m_cnt = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period_of(logic [3:0] r);
    int c;
    c = (r == 4'd1) ? 8 : (r == 4'd2) ? 9 : int'(r);
    return 1 << (c - 1);
  endfunction

  task automatic drive_ticks(int n, int gap, string tag);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      m_cnt = (m_cnt + 1) % 16384;
      if (rate_sel != 4'd0 && (pie_en || sqw_en) &&
          (m_cnt % period_of(rate_sel)) == 0) begin
        exp_t e;
        e.stamp = cyc + 1;
        e.fl    = pie_en ? 2'b11 : 2'b00;
        e.sq    = sqw_en;
        e.tag   = tag;
        q.push_back(e);
      end
      @(negedge clk);
      tick_en = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic settle(string tag);
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected events missing, actual count 0 expected %0d",
               tag, q.size(), q.size());
      q.delete();
    end
  endtask

  always @(negedge clk) begin
    if (!rst && evt_o) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL unexpected event at cycle %0d: actual evt=1 expected evt=0", cyc);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.stamp != cyc || e.fl != flags_o || e.sq != sqw_o) begin
          fails++;
          $display("FAIL %s: actual cyc=%0d flags=%b sqw=%b expected cyc=%0d flags=%b sqw=%b",
                   e.tag, cyc, flags_o, sqw_o, e.stamp, e.fl, e.sq);
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (evt_o !== 1'b0 || flags_o !== 2'b00 || sqw_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual evt=%b flags=%b sqw=%b expected 0 00 0",
               evt_o, flags_o, sqw_o);
    end
    rst = 1'b0;
    m_cnt = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    rate_sel = 4'd6; pie_en = 1'b1; sqw_en = 1'b0;
    drive_ticks(100, 1, "R1_R4_R6_R7 code 6");
    settle("R4");
    rate_sel = 4'd3; pie_en = 1'b0; sqw_en = 1'b1;
    drive_ticks(21, 0, "R8_R10 code 3 back-to-back");
    settle("R8");
    rate_sel = 4'd1; pie_en = 1'b1; sqw_en = 1'b1;
    drive_ticks(300, 0, "R5 code 1");
    settle("R5");
    rate_sel = 4'd2;
    drive_ticks(600, 0, "R5 code 2");
    settle("R5");
    rate_sel = 4'd0;
    drive_ticks(200, 0, "R2 code 0");
    settle("R2");
    rate_sel = 4'd5; pie_en = 1'b0; sqw_en = 1'b0;
    drive_ticks(200, 0, "R3 no consumer");
    settle("R3");
    rate_sel = 4'd9; pie_en = 1'b1;
    drive_ticks(100, 0, "R9 code 9");
    rate_sel = 4'd4;
    drive_ticks(70, 1, "R9 switched to code 4");
    settle("R9");
    rate_sel = 4'd15; pie_en = 1'b0; sqw_en = 1'b1;
    drive_ticks(16384 - m_cnt + 5, 0, "R4 code 15");
    settle("R4");
    rate_sel = 4'd7; pie_en = 1'b1;
    drive_ticks(50, 0, "R1 pre-reset");
    do_reset();
    q.delete();
    drive_ticks(140, 0, "R1 after reset code 7");
    settle("R1");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule